// File: doc/BRIEF.md
# Configuration Status Register with Write-One-Clear

This block holds the 16-bit status word of a bus-attached device's configuration header. Five of its bits are sticky event flags. The bus interface logic raises them with single-cycle pulses: detected parity error, parity error as master, received target abort, received master abort and signalled system error. The other bits are fixed fields that describe the device. Among them are a capability-list flag and a two-bit device-select timing code.

Software reads the word and clears selected flags by writing ones to their positions. A bus write can never set a flag. Each flag has its own qualifying condition:
- The master parity flag also needs the parity-error-response enable from the command register.
- The master-abort flag ignores special cycles.
- The detected-parity flag does not depend on the enable.

The read data path is combinational and has no side effects. Address decoding, bus protocol handling and the command register are outside this block.

Top module: `cfg_status_reg`

## Requirements
- R1: After reset, with the read strobe high, the read data is 16'h0210: all event flags are clear and only the fixed fields are set.
- R2: In every read, bits 3:0, 7:5 and 11 are 0, bit 4 is 1 and bits 10:9 are 2'b01. Writes and events never change these bits.
- R3: A write never sets an event flag (bits 8, 12, 13, 14, 15), whatever the write data.
- R4: In the clock after a write, an event flag whose write-data bit was 1 reads 0. An event flag whose write-data bit was 0 keeps its value.
- R5: Bit 8 sets only when the master-parity pulse arrives while the parity-error-response enable is 1.
- R6: Bit 12 sets in the clock after a received-target-abort pulse.
- R7: Bit 13 sets after a received-master-abort pulse, unless the special-cycle qualifier is high in the same clock.
- R8: Bit 14 sets after a system-error pulse.
- R9: Bit 15 sets after a detected-parity pulse, whether the parity-error-response enable is 0 or 1.
- R10: If an event and a write-one-clear hit the same flag in the same clock, the flag reads 1 afterwards.
- R11: The read data is 0 while the read strobe is low. Reading never changes the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data; each 1 clears the matching event flag |
| rd_en_i | input | 1 | Read strobe |
| perr_det_i | input | 1 | Pulse: parity error detected |
| perr_mst_i | input | 1 | Pulse: parity error asserted or observed while bus master |
| tgt_abort_i | input | 1 | Pulse: mastered transaction ended in target abort |
| mst_abort_i | input | 1 | Pulse: mastered transaction ended in master abort |
| special_cyc_i | input | 1 | Qualifier: the master-abort pulse belongs to a special cycle |
| serr_i | input | 1 | Pulse: device asserted its system-error output |
| perr_resp_en_i | input | 1 | Parity-error-response enable from the command register |
| rd_data_o | output | 16 | Status word, 0 while the read strobe is low |

## Verification
An event pulse and a software write-one-clear can hit the same flag in the same clock. Each outcome is judged separately:
- Directed cases pair every event with a write of all ones and expect the flag to read 1 in the next clock.
- Other cases clear only part of the flags and expect exactly the written-one positions to drop.
- Seeded random cycles drive events, enables, writes and reads together. They compare every read against a bench model built from the set-wins and clear-by-one rules, so collisions occur often and in many combinations.

// File: rtl/cfg_status_pkg.sv
package cfg_status_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned EVT_N  = 5;

  typedef enum logic [2:0] {
    EV_PERR_MST = 3'd0,
    EV_TGT_ABT  = 3'd1,
    EV_MST_ABT  = 3'd2,
    EV_SERR     = 3'd3,
    EV_PERR_DET = 3'd4
  } evt_idx_e;

  // bit position of each event flag inside the status word
  function automatic int unsigned evt_pos(input int unsigned idx);
    case (idx)
      0:       evt_pos = 8;
      1:       evt_pos = 12;
      2:       evt_pos = 13;
      3:       evt_pos = 14;
      default: evt_pos = 15;
    endcase
  endfunction

  typedef struct packed {
    logic perr_det;
    logic perr_mst;
    logic tgt_abort;
    logic mst_abort;
    logic special_cyc;
    logic serr;
  } evt_in_t;
endpackage

// File: rtl/cfg_status_evt_qual.sv
module cfg_status_evt_qual
  import cfg_status_pkg::*;
(
  input  evt_in_t            evt_i,
  input  logic               perr_resp_en_i,
  output logic [EVT_N-1:0]   set_o
);
  always_comb begin
    set_o              = '0;
    set_o[EV_PERR_MST] = evt_i.perr_mst & perr_resp_en_i;
    set_o[EV_TGT_ABT]  = evt_i.tgt_abort;
    set_o[EV_MST_ABT]  = evt_i.mst_abort & ~evt_i.special_cyc;
    set_o[EV_SERR]     = evt_i.serr;
    set_o[EV_PERR_DET] = evt_i.perr_det;
  end
endmodule

// File: rtl/cfg_status_sticky.sv
module cfg_status_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;  // set beats clear
    else if (clr_i)  q_o <= 1'b0;
  end

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/cfg_status_reg.sv
module cfg_status_reg
  import cfg_status_pkg::*;
#(
  parameter logic [1:0] DEVSEL_TIMING = 2'b01,
  parameter logic       CAP_LIST      = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              perr_det_i,
  input  logic              perr_mst_i,
  input  logic              tgt_abort_i,
  input  logic              mst_abort_i,
  input  logic              special_cyc_i,
  input  logic              serr_i,
  input  logic              perr_resp_en_i,
  output logic [WORD_W-1:0] rd_data_o
);
  evt_in_t          evt;
  logic [EVT_N-1:0] evt_set;
  logic [EVT_N-1:0] evt_q;
  logic [WORD_W-1:0] status;

  assign evt = '{perr_det: perr_det_i, perr_mst: perr_mst_i, tgt_abort: tgt_abort_i,
                 mst_abort: mst_abort_i, special_cyc: special_cyc_i, serr: serr_i};

  cfg_status_evt_qual u_qual (
    .evt_i          (evt),
    .perr_resp_en_i (perr_resp_en_i),
    .set_o          (evt_set)
  );

  for (genvar g = 0; g < EVT_N; g++) begin : g_evt
    localparam int unsigned POS = evt_pos(g);
    cfg_status_sticky u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_set[g]),
      .clr_i  (wr_en_i & wr_data_i[POS]),
      .q_o    (evt_q[g])
    );
  end

  always_comb begin
    status        = '0;
    status[4]     = CAP_LIST;
    status[10:9]  = DEVSEL_TIMING;
    for (int i = 0; i < EVT_N; i++) status[evt_pos(i)] = evt_q[i];
  end

  assign rd_data_o = rd_en_i ? status : '0;

  p_const_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> (rd_data_o[3:0] == 4'h0 && rd_data_o[7:5] == 3'h0 &&
                 rd_data_o[11] == 1'b0 && rd_data_o[4] && rd_data_o[10:9] == 2'b01));
  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rd_data_o == '0));
  p_mabort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_q[EV_MST_ABT]) |-> $past(mst_abort_i && !special_cyc_i));
  p_perr_mst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_q[EV_PERR_MST]) |-> $past(perr_mst_i && perr_resp_en_i));
endmodule

// File: tb/cfg_status_reg_test.sv
module cfg_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] wd = '0;
  logic        p_det = 0, p_mst = 0, t_abt = 0, m_abt = 0, spc = 0, serr = 0, pen = 0;
  logic [15:0] rd;
  int          checks = 0, errors = 0;
  logic [15:0] flags = '0;  // model of event bits in word positions

  always #4 clk = ~clk;

  cfg_status_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_data_i(wd), .rd_en_i(re),
    .perr_det_i(p_det), .perr_mst_i(p_mst), .tgt_abort_i(t_abt), .mst_abort_i(m_abt),
    .special_cyc_i(spc), .serr_i(serr), .perr_resp_en_i(pen), .rd_data_o(rd)
  );

  localparam logic [15:0] EVT_MASK = 16'hF100;
  localparam logic [15:0] FIXED    = 16'h0210;

  function automatic logic [15:0] set_vec(input logic pd, pm, ta, ma, sc, se, en);
    logic [15:0] s = '0;
    s[8]  = pm & en;
    s[12] = ta;
    s[13] = ma & ~sc;
    s[14] = se;
    s[15] = pd;
    return s;
  endfunction

  function automatic logic [15:0] exp_rd(input logic r, input logic [15:0] f);
    return r ? (FIXED | (f & EVT_MASK)) : 16'h0;
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (rd !== exp) begin
      errors++;
      $display("FAIL %s: rd=%h exp=%h", tag, rd, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, sample 1ns later
  task automatic cyc(input logic w, input logic [15:0] d, input logic r,
                     input logic pd, pm, ta, ma, sc, se, en);
    @(negedge clk);
    we = w; wd = d; re = r; p_det = pd; p_mst = pm; t_abt = ta;
    m_abt = ma; spc = sc; serr = se; pen = en;
    @(posedge clk);
    flags = set_vec(pd, pm, ta, ma, sc, se, en) | (flags & ~(w ? d : 16'h0));
    #1;
  endtask

  task automatic idle_read();
    cyc(0, 16'h0, 1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: rd=%h exp=done", rd);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1 re = 1'b1; #1;
    check("R1 reset value", 16'h0210);
    @(negedge clk); rst_n = 1'b1;
    idle_read(); check("R1 after reset release", 16'h0210);

    cyc(1, 16'hFFFF, 1, 0, 0, 0, 0, 0, 0, 0); check("R3 write ones sets nothing", 16'h0210);
    cyc(1, 16'h0000, 1, 0, 0, 0, 0, 0, 0, 0); check("R2 fixed fields after writes", 16'h0210);

    cyc(0, 0, 1, 0, 1, 0, 0, 0, 0, 0); check("R5 master parity with enable 0", 16'h0210);
    cyc(0, 0, 1, 0, 1, 0, 0, 0, 0, 1); check("R5 master parity with enable 1", 16'h0310);
    cyc(0, 0, 1, 0, 0, 1, 0, 0, 0, 0); check("R6 target abort", 16'h1310);
    cyc(0, 0, 1, 0, 0, 0, 1, 1, 0, 0); check("R7 special cycle blocks master abort", 16'h1310);
    cyc(0, 0, 1, 0, 0, 0, 1, 0, 0, 0); check("R7 master abort", 16'h3310);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 1, 0); check("R8 system error", 16'h7310);
    cyc(0, 0, 1, 1, 0, 0, 0, 0, 0, 0); check("R9 detected parity, enable 0", 16'hF310);

    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); check("R11 strobe low reads zero", 16'h0000);
    idle_read(); check("R11 read leaves flags", 16'hF310);
    idle_read(); check("R11 second read identical", 16'hF310);

    cyc(1, 16'h5100, 1, 0, 0, 0, 0, 0, 0, 0); check("R4 partial clear", 16'hA210);
    cyc(1, 16'hFFFF, 1, 0, 0, 0, 0, 0, 0, 0); check("R4 clear all", 16'h0210);
    cyc(1, 16'h0000, 1, 1, 0, 0, 0, 0, 0, 1); check("R9 detected parity, enable 1", 16'h8210);

    cyc(1, 16'hFFFF, 1, 1, 1, 1, 1, 0, 1, 1); check("R10 all events with full clear", 16'hF310);
    cyc(1, 16'hFFFF, 1, 0, 0, 1, 0, 0, 0, 0); check("R10 target abort beats clear", 16'h1210);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      cyc(($urandom % 3) == 0, d, ($urandom % 4) != 0,
          ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
          ($urandom % 6) == 0, ($urandom % 2) == 0, ($urandom % 6) == 0, $urandom % 2);
      check("R4 R10 random against model", exp_rd(re, flags));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule